// File: doc/BRIEF.md
# Vectored Interrupt Controller

This block collects raw event signals around a small microcontroller core and turns them into vectored interrupt requests. Two external pins pass through a programmable edge detector. An over-voltage detect pulse feeds one source. A multi-mode serial unit feeds one source, which merges a different group of status conditions for each operating mode. Each timer module feeds two sources: one for its compare-A match and one for its compare-P match. Every source latches into its own request flag. The flag stays pending until the interrupt is taken or software clears it.

A pending flag is taken when four conditions hold at once: the global enable is set, the source's own enable is set, the core reports that its call stack is not full, and no pending enabled source has a lower index. When a flag is taken, the block gives the core a one-cycle take pulse, the vector index and the vector address. In the same clock edge it clears the serviced flag and the global enable. A return-from-interrupt strobe sets the global enable again. Software reaches flags, enables and edge selects through a small register port.

Source index map: 0 = external pin 0, 1 = external pin 1, 2 = over-voltage, 3 = serial unit, 4+2t = compare-A of timer t, 5+2t = compare-P of timer t.

Top module: `irq_vector_ctrl`

## Requirements
- R1: After a synchronous active-low reset, all flags, all enables, the global enable and both edge selects are zero. `irq_take` is low, `irq_idx` is 0 and `irq_addr` equals `VEC_BASE`.
- R2: Each external pin has a 2-bit edge select: 00 off, 01 rising, 10 falling, 11 both edges. A selected edge sets the pin's flag one cycle later. With select 00, pin activity leaves the flag clear. The selects are control register (address 2) bits [2:1] for pin 0 and bits [4:3] for pin 1.
- R3: Any event sets its flag at the next clock edge, whatever the enables and the global enable are. The flag then holds until it is cleared. Address 0 reads the flags, with bit i for source i.
- R4: A pending flag is taken only when the global enable (control bit 0) and that source's enable (address 1, bit i) are both set.
- R5: While `stack_full` is high, no interrupt is taken and the pending flags are unchanged.
- R6: Acceptance produces `irq_take` high for exactly one cycle, one cycle after the flag is visible. In the same edge, the serviced flag and the global enable are cleared.
- R7: When several enabled flags are pending, the lowest source index is taken.
- R8: `irq_idx` follows the source index map, and `irq_addr` equals `VEC_BASE + 4*irq_idx`. Both are updated on acceptance and hold their values between acceptances.
- R9: The serial source is the OR of the three sync conditions in mode 00 (SPI) and mode 01 (I2C), and the OR of the six UART conditions in mode 10. Mode 11 produces no event.
- R10: A `reti` pulse sets the global enable. Acceptance takes precedence over `reti`, and `reti` takes precedence over a software write of control bit 0 in the same cycle.
- R11: Writing 1s to address 0 clears the matching flags. When a hardware event hits a flag in the same cycle as a software clear or an acceptance clear of that flag, the event wins and the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_pin | input | 2 | External interrupt pins, already synchronised |
| ovp_evt | input | 1 | Over-voltage detect pulse |
| ser_mode | input | 2 | Serial unit mode: 00 SPI, 01 I2C, 10 UART, 11 none |
| ser_sync_ev | input | 3 | Byte done, address match, bus time-out |
| ser_uart_ev | input | 6 | Transmit empty, transmitter idle, receive ready, overrun, address detect, RX wake |
| tmr_cmpa | input | 3 | Compare-A match pulse per timer |
| tmr_cmpp | input | 3 | Compare-P match pulse per timer |
| stack_full | input | 1 | Core call stack is full |
| reti | input | 1 | Return-from-interrupt strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 flags, 1 enables, 2 control |
| reg_wdata | input | 10 | Register write data |
| reg_rdata | output | 10 | Register read data for `reg_addr` |
| irq_take | output | 1 | One-cycle acceptance pulse |
| irq_idx | output | 4 | Index of the accepted source |
| irq_addr | output | 16 | Vector address of the accepted source |

## Verification
The directed patterns each separate one pair of behaviours:
- Events with all enables off show that latching does not depend on enabling.
- Enables on with the global enable off, and the reverse, show that both gates are needed.
- A stack-full window with everything enabled shows that pending requests wait instead of being dropped.
- Draining many pending flags one `reti` at a time exposes the fixed priority order and the address arithmetic.
- Edge-select sweeps and serial-mode sweeps, with events sent on the inactive group, show that each selection both passes and blocks the right conditions.
- A software clear in the same cycle as a new event, and a `reti` against a control write, pin down both same-cycle precedence rules.

A long randomised run then compares every output with the bench model on every clock.

// File: rtl/irqv_pkg.sv
// Shared types and constants for the vectored interrupt controller.
// Assumes source order ext0, ext1, over-voltage, serial, then timer pairs.
package irqv_pkg;
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_t;

    typedef enum logic [1:0] {
        SER_SPI  = 2'b00,
        SER_I2C  = 2'b01,
        SER_UART = 2'b10,
        SER_NONE = 2'b11
    } ser_mode_t;

    localparam int SRC_EXT0     = 0;
    localparam int SRC_EXT1     = 1;
    localparam int SRC_OVP      = 2;
    localparam int SRC_SER      = 3;
    localparam int SRC_TMR_BASE = 4;

    localparam logic [1:0] REG_FLAG = 2'd0;
    localparam logic [1:0] REG_EN   = 2'd1;
    localparam logic [1:0] REG_CTRL = 2'd2;
endpackage

// File: rtl/irqv_edge_sel.sv
// Edge detector for one external interrupt pin with a 4-way select.
// Assumes the pin is already synchronous to clk; the previous value resets to 0.
module irqv_edge_sel
    import irqv_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      pin,
    input  edge_sel_t sel,
    output logic      evt
);
    logic prev_q;

    // Remember the pin level of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin;
    end

    // Pick which transitions count as an event.
    always_comb begin
        unique case (sel)
            EDGE_RISE: evt = pin & ~prev_q;
            EDGE_FALL: evt = ~pin & prev_q;
            EDGE_BOTH: evt = pin ^ prev_q;
            default:   evt = 1'b0;
        endcase
    end

    // R2
    edge_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_OFF) |-> !evt);
    // R2
    rise_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == EDGE_RISE && evt) |-> pin);
endmodule

// File: rtl/irqv_serial_merge.sv
// Merges the serial unit's status conditions into one event by mode.
// Assumes the conditions are single-cycle or level signals from the serial unit.
module irqv_serial_merge
    import irqv_pkg::*;
#(
    parameter int SYNC_N = 3,
    parameter int UART_N = 6
) (
    input  ser_mode_t         mode,
    input  logic [SYNC_N-1:0] sync_ev,
    input  logic [UART_N-1:0] uart_ev,
    output logic              evt
);
    // Select the condition group that belongs to the active mode.
    always_comb begin
        unique case (mode)
            SER_SPI, SER_I2C: evt = |sync_ev;
            SER_UART:         evt = |uart_ev;
            default:          evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/irqv_flag_bank.sv
// Request flags: set by events, cleared by software (W1C) or by acceptance.
// Assumes an event in the same cycle as any clear leaves the flag set.
module irqv_flag_bank #(
    parameter int N = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_ev,
    input  logic [N-1:0] sw_clr,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] flags
);
    // Update every flag; set has priority over both clears.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~sw_clr & ~ack_clr) | set_ev;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R11
        event_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_ev[i] |=> flags[i]);
        // R3
        flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !sw_clr[i] && !ack_clr[i]) |=> flags[i]);
    end
endmodule

// File: rtl/irqv_arbiter.sv
// Fixed-priority acceptance: lowest enabled pending index wins.
// Assumes flags and enables are registered; the outputs are combinational.
module irqv_arbiter #(
    parameter int N  = 10,
    parameter int IW = 4
) (
    input  logic [N-1:0]  flags,
    input  logic [N-1:0]  en,
    input  logic          gie,
    input  logic          stack_full,
    output logic          accept,
    output logic [N-1:0]  grant,
    output logic [IW-1:0] win_idx
);
    logic [N-1:0] pend;

    assign pend   = flags & en;
    assign accept = gie & ~stack_full & (|pend);

    // Scan from the top so that the lowest pending index is the last one written.
    always_comb begin
        win_idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (pend[i]) win_idx = IW'(i);
        end
    end

    // Turn the winner into a one-hot clear, only when the request is taken.
    always_comb begin
        grant = '0;
        if (accept) grant[win_idx] = 1'b1;
    end
endmodule

// File: rtl/irq_vector_ctrl.sv
// Vectored interrupt controller top: the edge detectors, the serial merge,
// the flag bank, the arbiter, the register port and the vector outputs.
// Assumes every input is synchronous to clk. The register port writes in one cycle
// and reads combinationally.
module irq_vector_ctrl
    import irqv_pkg::*;
#(
    parameter int          NUM_TMR  = 3,
    parameter int          AW       = 16,
    parameter logic [15:0] VEC_BASE = 16'h0040,
    localparam int         NSRC     = SRC_TMR_BASE + 2 * NUM_TMR,
    localparam int         IW       = $clog2(NSRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [1:0]         ext_pin,
    input  logic               ovp_evt,
    input  logic [1:0]         ser_mode,
    input  logic [2:0]         ser_sync_ev,
    input  logic [5:0]         ser_uart_ev,
    input  logic [NUM_TMR-1:0] tmr_cmpa,
    input  logic [NUM_TMR-1:0] tmr_cmpp,
    input  logic               stack_full,
    input  logic               reti,
    input  logic               reg_we,
    input  logic [1:0]         reg_addr,
    input  logic [NSRC-1:0]    reg_wdata,
    output logic [NSRC-1:0]    reg_rdata,
    output logic               irq_take,
    output logic [IW-1:0]      irq_idx,
    output logic [AW-1:0]      irq_addr
);
    logic [NSRC-1:0] en_q;
    logic            gie_q;
    logic [1:0]      edge0_q, edge1_q;
    logic [NSRC-1:0] flags, src_ev, sw_clr, grant;
    logic            ext0_evt, ext1_evt, ser_evt, accept;
    logic [IW-1:0]   win_idx;
    logic            wr_flag, wr_en, wr_ctrl;

    assign wr_flag = reg_we && (reg_addr == REG_FLAG);
    assign wr_en   = reg_we && (reg_addr == REG_EN);
    assign wr_ctrl = reg_we && (reg_addr == REG_CTRL);
    assign sw_clr  = wr_flag ? reg_wdata : '0;

    irqv_edge_sel u_edge0 (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin[0]),
        .sel(edge_sel_t'(edge0_q)), .evt(ext0_evt)
    );
    irqv_edge_sel u_edge1 (
        .clk(clk), .rst_n(rst_n), .pin(ext_pin[1]),
        .sel(edge_sel_t'(edge1_q)), .evt(ext1_evt)
    );

    irqv_serial_merge #(.SYNC_N(3), .UART_N(6)) u_ser (
        .mode(ser_mode_t'(ser_mode)), .sync_ev(ser_sync_ev),
        .uart_ev(ser_uart_ev), .evt(ser_evt)
    );

    // Place each event on its source index.
    always_comb begin
        src_ev           = '0;
        src_ev[SRC_EXT0] = ext0_evt;
        src_ev[SRC_EXT1] = ext1_evt;
        src_ev[SRC_OVP]  = ovp_evt;
        src_ev[SRC_SER]  = ser_evt;
        for (int t = 0; t < NUM_TMR; t++) begin
            src_ev[SRC_TMR_BASE + 2 * t]     = tmr_cmpa[t];
            src_ev[SRC_TMR_BASE + 2 * t + 1] = tmr_cmpp[t];
        end
    end

    irqv_flag_bank #(.N(NSRC)) u_flags (
        .clk(clk), .rst_n(rst_n), .set_ev(src_ev),
        .sw_clr(sw_clr), .ack_clr(grant), .flags(flags)
    );

    irqv_arbiter #(.N(NSRC), .IW(IW)) u_arb (
        .flags(flags), .en(en_q), .gie(gie_q), .stack_full(stack_full),
        .accept(accept), .grant(grant), .win_idx(win_idx)
    );

    // Per-source enables and edge selects, written through the register port.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= '0;
            edge0_q <= 2'b00;
            edge1_q <= 2'b00;
        end else begin
            if (wr_en) en_q <= reg_wdata;
            if (wr_ctrl) begin
                edge0_q <= reg_wdata[2:1];
                edge1_q <= reg_wdata[4:3];
            end
        end
    end

    // Global enable: acceptance clears it, reti sets it, otherwise software writes it.
    always_ff @(posedge clk) begin
        if (!rst_n)       gie_q <= 1'b0;
        else if (accept)  gie_q <= 1'b0;
        else if (reti)    gie_q <= 1'b1;
        else if (wr_ctrl) gie_q <= reg_wdata[0];
    end

    // Vector outputs: a one-cycle take pulse, with the index and address held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_take <= 1'b0;
            irq_idx  <= '0;
            irq_addr <= AW'(VEC_BASE);
        end else begin
            irq_take <= accept;
            if (accept) begin
                irq_idx  <= win_idx;
                irq_addr <= AW'(VEC_BASE) + (AW'(win_idx) << 2);
            end
        end
    end

    // Read mux for the register port.
    always_comb begin
        unique case (reg_addr)
            REG_FLAG: reg_rdata = flags;
            REG_EN:   reg_rdata = en_q;
            REG_CTRL: reg_rdata = NSRC'({edge1_q, edge0_q, gie_q});
            default:  reg_rdata = '0;
        endcase
    end

    // R5
    take_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !$past(stack_full));
    // R4
    take_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ($past(gie_q) && $past(|(en_q & flags))));
    // R6
    take_masks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> !gie_q);
    // R6
    take_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);
    // R7
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));
    // R8
    vec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> $stable(irq_idx) && $stable(irq_addr));
endmodule

// File: tb/irq_vector_ctrl_test.sv
`timescale 1ns/1ps
module irq_vector_ctrl_test;
    localparam int          NT   = 3;
    localparam int          NS   = 4 + 2 * NT;
    localparam logic [15:0] BASE = 16'h0040;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    ext_pin = '0;
    logic          ovp_evt = 1'b0;
    logic [1:0]    ser_mode = '0;
    logic [2:0]    ser_sync_ev = '0;
    logic [5:0]    ser_uart_ev = '0;
    logic [NT-1:0] tmr_cmpa = '0, tmr_cmpp = '0;
    logic          stack_full = 1'b0, reti = 1'b0;
    logic          reg_we = 1'b0;
    logic [1:0]    reg_addr = '0;
    logic [NS-1:0] reg_wdata = '0;
    logic [NS-1:0] reg_rdata;
    logic          irq_take;
    logic [3:0]    irq_idx;
    logic [15:0]   irq_addr;

    int    checks = 0, errors = 0;
    bit    done = 1'b0;
    string cur_req = "R1";

    irq_vector_ctrl #(.NUM_TMR(NT), .AW(16), .VEC_BASE(BASE)) uut (
        .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ovp_evt(ovp_evt),
        .ser_mode(ser_mode), .ser_sync_ev(ser_sync_ev), .ser_uart_ev(ser_uart_ev),
        .tmr_cmpa(tmr_cmpa), .tmr_cmpp(tmr_cmpp), .stack_full(stack_full),
        .reti(reti), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq_take(irq_take), .irq_idx(irq_idx),
        .irq_addr(irq_addr)
    );

    always #10 clk = ~clk;

    // Reference state, kept behaviourally.
    logic [NS-1:0] m_flags, m_en;
    logic          m_gie, m_take;
    logic [1:0]    m_e0, m_e1, m_prev;
    int            m_idx;
    logic [15:0]   m_addr;

    function automatic logic edge_hit(logic [1:0] s, logic p, logic c);
        case (s)
            2'b01:   return c & ~p;
            2'b10:   return ~c & p;
            2'b11:   return c ^ p;
            default: return 1'b0;
        endcase
    endfunction

    task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // Advance the model at each edge, then compare the outputs 5 ns later.
    always @(posedge clk) begin
        logic [NS-1:0] ev, pend, nflags;
        logic acc;
        int win;
        if (!rst_n) begin
            m_flags = '0; m_en = '0; m_gie = 0; m_take = 0; m_e0 = 0; m_e1 = 0;
            m_prev = 0; m_idx = 0; m_addr = BASE;
        end else begin
            ev = '0;
            ev[0] = edge_hit(m_e0, m_prev[0], ext_pin[0]);
            ev[1] = edge_hit(m_e1, m_prev[1], ext_pin[1]);
            ev[2] = ovp_evt;
            ev[3] = (ser_mode <= 2'd1) ? |ser_sync_ev : (ser_mode == 2'd2) ? |ser_uart_ev : 1'b0;
            for (int t = 0; t < NT; t++) begin
                ev[4 + 2 * t] = tmr_cmpa[t];
                ev[5 + 2 * t] = tmr_cmpp[t];
            end
            pend = m_flags & m_en;
            acc  = m_gie && (pend != 0) && !stack_full;
            win  = 0;
            for (int i = NS - 1; i >= 0; i--) if (pend[i]) win = i;
            nflags = m_flags;
            if (reg_we && reg_addr == 2'd0) nflags = nflags & ~reg_wdata;
            if (acc) nflags[win] = 1'b0;
            m_flags = nflags | ev;
            if (acc) m_gie = 0;
            else if (reti) m_gie = 1;
            else if (reg_we && reg_addr == 2'd2) m_gie = reg_wdata[0];
            if (reg_we && reg_addr == 2'd1) m_en = reg_wdata;
            if (reg_we && reg_addr == 2'd2) begin m_e0 = reg_wdata[2:1]; m_e1 = reg_wdata[4:3]; end
            m_take = acc;
            if (acc) begin m_idx = win; m_addr = BASE + 16'(4 * win); end
            m_prev = ext_pin;
        end
        #5;
        check(cur_req, "irq_take", 32'(irq_take), 32'(m_take));
        check(cur_req, "irq_idx", 32'(irq_idx), 32'(m_idx));
        check(cur_req, "irq_addr", 32'(irq_addr), 32'(m_addr));
        case (reg_addr)
            2'd0: check(cur_req, "flags", 32'(reg_rdata), 32'(m_flags));
            2'd1: check(cur_req, "enables", 32'(reg_rdata), 32'(m_en));
            2'd2: check(cur_req, "ctrl", 32'(reg_rdata), 32'({m_e1, m_e0, m_gie}));
            default: check(cur_req, "unused", 32'(reg_rdata), 32'h0);
        endcase
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [NS-1:0] d);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        tick(1);
        reg_we = 0; reg_addr = 2'd0;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst_n = 1;
        tick(1);
        // R1: reset state seen through the port.
        cur_req = "R1";
        check("R1", "take after reset", 32'(irq_take), 0);
        check("R1", "addr after reset", 32'(irq_addr), 32'(BASE));
        reg_addr = 2'd2; tick(1);
        check("R1", "ctrl after reset", 32'(reg_rdata), 0);
        reg_addr = 2'd1; tick(1);
        reg_addr = 2'd0; tick(1);

        // R3: events latch with everything disabled.
        cur_req = "R3";
        ovp_evt = 1; tmr_cmpa[1] = 1; ser_sync_ev = 3'b010; tick(1);
        ovp_evt = 0; tmr_cmpa[1] = 0; ser_sync_ev = 0; tick(2);
        check("R3", "latched flags", 32'(reg_rdata), 32'h04C);

        // R4: source enables without the global enable, then the reverse.
        cur_req = "R4";
        wr(2'd1, '1); tick(4);
        check("R4", "no take gie off", 32'(irq_take), 0);
        wr(2'd1, '0); wr(2'd2, 10'h001); tick(4);

        // R5: everything enabled but the stack is full.
        cur_req = "R5";
        stack_full = 1; wr(2'd1, '1); tick(4);
        check("R5", "flags pending", 32'(reg_rdata), 32'h04C);

        // R7 and R8: drain in priority order, one reti per take.
        cur_req = "R7";
        tmr_cmpp = '1; ext_pin = 0; tick(1); tmr_cmpp = 0;
        stack_full = 0;
        for (int k = 0; k < 8; k++) begin
            tick(3);
            reti = 1; tick(1); reti = 0;
        end
        cur_req = "R8";
        tmr_cmpa[2] = 1; tick(1); tmr_cmpa[2] = 0; tick(4);
        reti = 1; tick(1); reti = 0; tick(3);

        // R2: each edge select on both pins, all enables off.
        cur_req = "R2";
        wr(2'd1, '0);
        for (int s = 0; s < 4; s++) begin
            wr(2'd2, NS'((s << 3) | (s << 1)));
            ext_pin = 2'b01; tick(2);
            ext_pin = 2'b10; tick(2);
            ext_pin = 2'b00; tick(2);
            wr(2'd0, '1); tick(1);
        end

        // R9: every serial mode against both condition groups.
        cur_req = "R9";
        for (int m = 0; m < 4; m++) begin
            ser_mode = 2'(m);
            ser_sync_ev = 3'b100; tick(1); ser_sync_ev = 0; tick(1);
            wr(2'd0, '1);
            ser_uart_ev = 6'b100000; tick(1); ser_uart_ev = 0; tick(1);
            wr(2'd0, '1);
        end
        ser_mode = 0;

        // R11: a software clear and an event on the same flag in the same cycle.
        cur_req = "R11";
        ovp_evt = 1; tick(1); ovp_evt = 0; tick(1);
        ovp_evt = 1; wr(2'd0, NS'(4)); ovp_evt = 0; tick(1);
        check("R11", "event beats clear", 32'(reg_rdata[2]), 1);
        wr(2'd0, '1); tick(1);

        // R10: a reti and a control write of 0 in the same cycle.
        cur_req = "R10";
        reti = 1; wr(2'd2, '0); reti = 0;
        reg_addr = 2'd2; tick(1);
        check("R10", "reti beats write", 32'(reg_rdata[0]), 1);
        reg_addr = 0;

        // R6: long randomised traffic, compared with the model on every clock.
        cur_req = "R6";
        for (int c = 0; c < 4000; c++) begin
            ext_pin     = 2'($urandom);
            ovp_evt     = ($urandom % 9) == 0;
            ser_mode    = 2'($urandom);
            ser_sync_ev = (($urandom % 6) == 0) ? 3'($urandom) : 3'b0;
            ser_uart_ev = (($urandom % 6) == 0) ? 6'($urandom) : 6'b0;
            tmr_cmpa    = (($urandom % 5) == 0) ? NT'($urandom) : '0;
            tmr_cmpp    = (($urandom % 5) == 0) ? NT'($urandom) : '0;
            stack_full  = ($urandom % 4) == 0;
            reti        = ($urandom % 5) == 0;
            reg_we      = ($urandom % 8) == 0;
            reg_addr    = 2'($urandom);
            reg_wdata   = NS'($urandom);
            tick(1);
        end
        reg_we = 0; reti = 0;
        tick(2);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule